// File: doc/BRIEF.md
# Aliased General Register File

This block is the 64-bit integer register file of a load-store processor core. It holds thirty-one general registers plus a stored stack pointer. Index 31 has two meanings, and each access chooses one with its own mode bit. In stack-pointer mode, index 31 reaches the stored stack pointer. In zero mode, index 31 reads as zero and a write to it is dropped. The block has two combinational read ports and one write port, all sharing one clock.

Each read port asks for 8, 16, 32 or 64 bits, signed or unsigned, and the result is extended to the full width. The write port writes either the full 64 bits or a 32-bit value whose upper half is cleared. A dedicated link-save input stores a next-instruction address into register 30 and wins over a general write to that register in the same cycle. A four-bit condition-flag register supports masked loads and bulk set and clear operations.

Top module: `aliased_gpr_file`

## Requirements
- R1: When a read port's mode bit is 0 (zero mode), a read of index 31 returns 0 at every access size.
- R2: A write to index 31 with the write mode bit at 0 leaves every register, the stack pointer included, unchanged.
- R3: With the mode bit at 1, index 31 reads and writes a stored stack pointer that is separate from registers 0 to 30.
- R4: When wrWide is 0 the write stores wrData[31:0] in bits 31:0 and forces bits 63:32 to zero. When wrWide is 1 all 64 bits are stored.
- R5: Read size encoding: 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. Narrow reads return the low bits. When rdSign is 1 they are sign-extended, and when it is 0 they are zero-extended.
- R6: The flags are held as flagsOut[3]=N, [2]=Z, [1]=C, [0]=V. Bits 7:4 of flagMask and flagValue have no effect.
- R7: flagOp encoding: 0 hold, 1 masked load (selected bits take flagValue), 2 set the mask bits, 3 clear the mask bits. Flags outside the mask never change.
- R8: When linkSave is 1, register 30 takes linkAddr at the next rising edge.
- R9: Reads are combinational. Writes land at the rising edge, so a read of a register that is being written in the same cycle returns the old value.
- R10: A synchronous active-high reset clears every register, the stack pointer and the flags to zero.
- R11: When linkSave and a general write to register 30 occur in the same cycle, register 30 takes linkAddr. A general write to any other register in that cycle still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdAddrA | input | 5 | Read port A index |
| rdSpModeA | input | 1 | Port A index-31 mode: 1 stack pointer, 0 zero |
| rdSizeA | input | 2 | Port A access size |
| rdSignA | input | 1 | Port A sign-extend enable |
| rdDataA | output | 64 | Port A extended read data |
| rdAddrB | input | 5 | Read port B index |
| rdSpModeB | input | 1 | Port B index-31 mode |
| rdSizeB | input | 2 | Port B access size |
| rdSignB | input | 1 | Port B sign-extend enable |
| rdDataB | output | 64 | Port B extended read data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Write index |
| wrSpMode | input | 1 | Write index-31 mode |
| wrWide | input | 1 | 1 for a 64-bit write, 0 for a 32-bit write with the upper half cleared |
| wrData | input | 64 | Write data |
| linkSave | input | 1 | Store linkAddr into register 30 |
| linkAddr | input | 64 | Next-instruction address to save |
| flagOp | input | 2 | Flag operation |
| flagMask | input | 8 | Flag select mask; only bits 3:0 are used |
| flagValue | input | 8 | Flag load value; only bits 3:0 are used |
| flagsOut | output | 4 | N, Z, C, V flags |

## Verification
The assertions check the port-level rules on every cycle. These are zero-mode reads of index 31, zero-filled upper bits on unsigned narrow reads, cleared upper halves after 32-bit writes, and unmasked flags holding through any flag operation. Some behaviours only the bench scenarios can show. These are that a dropped zero-mode write leaves the stack pointer intact, that the stack pointer is separate storage, the same-cycle old-value read, and link-save priority over a colliding write. The bench covers them with full sweeps over every index, mode, size and sign, and over all 256 mask and value pairs.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int NUM_GPR   = 31;
  localparam int IDX_W     = $clog2(NUM_GPR + 1);
  localparam int LINK_IDX  = NUM_GPR - 1;
  localparam int NUM_FLAGS = 4;
  localparam int FLAG_IN_W = 8;
  localparam int NUM_RD    = 2;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_LOAD = 2'd1,
    FLG_SET  = 2'd2,
    FLG_CLR  = 2'd3
  } flagOp_e;

  typedef struct packed {
    logic             gprWe;
    logic [IDX_W-1:0] gprIdx;
    logic             narrow;
    logic             linkWe;
    flagOp_e          flagOp;
  } ctrl_t;
endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic             wrSpMode,
  input  logic             wrWide,
  input  logic             linkSave,
  input  logic [1:0]       flagOpIn,
  output ctrl_t            ctrl
);
  logic aliasHit;
  logic linkClash;

  assign aliasHit  = (wrAddr == IDX_W'(NUM_GPR));
  assign linkClash = linkSave && (wrAddr == IDX_W'(LINK_IDX));

  always_comb begin
    ctrl.gprWe  = wrEn && (!aliasHit || wrSpMode) && !linkClash;
    ctrl.gprIdx = wrAddr;
    ctrl.narrow = !wrWide;
    ctrl.linkWe = linkSave;
    ctrl.flagOp = flagOp_e'(flagOpIn);
  end
endmodule

// File: rtl/gpr_datapath.sv
module gpr_datapath
  import gpr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ctrl_t                        ctrl,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [DATA_W-1:0]            linkAddr,
  input  logic [FLAG_IN_W-1:0]         flagMask,
  input  logic [FLAG_IN_W-1:0]         flagValue,
  input  logic [NUM_RD-1:0][IDX_W-1:0] rdAddr,
  input  logic [NUM_RD-1:0]            rdSpMode,
  input  logic [NUM_RD-1:0][1:0]       rdSize,
  input  logic [NUM_RD-1:0]            rdSign,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  output logic [NUM_FLAGS-1:0]         flagsOut
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int ENTRIES = NUM_GPR + 1;

  logic [DATA_W-1:0]    gprQ [ENTRIES];
  logic [DATA_W-1:0]    wrVal;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] maskEff;
  logic [NUM_FLAGS-1:0] valEff;
  logic                 unusedFlagHi;

  assign wrVal = ctrl.narrow ? {{(DATA_W-HALF_W){1'b0}}, wrData[HALF_W-1:0]} : wrData;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) gprQ[i] <= '0;
    end else begin
      if (ctrl.gprWe) gprQ[ctrl.gprIdx] <= wrVal;
      if (ctrl.linkWe) gprQ[LINK_IDX] <= linkAddr;
    end
  end

  assign maskEff      = flagMask[NUM_FLAGS-1:0];
  assign valEff       = flagValue[NUM_FLAGS-1:0];
  assign unusedFlagHi = ^{flagMask[FLAG_IN_W-1:NUM_FLAGS], flagValue[FLAG_IN_W-1:NUM_FLAGS]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ <= '0;
    end else begin
      case (ctrl.flagOp)
        FLG_LOAD: flagQ <= (flagQ & ~maskEff) | (valEff & maskEff);
        FLG_SET:  flagQ <= flagQ | maskEff;
        FLG_CLR:  flagQ <= flagQ & ~maskEff;
        default:  flagQ <= flagQ;
      endcase
    end
  end

  assign flagsOut = flagQ;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    logic [DATA_W-1:0] rawVal;
    logic              zeroSel;

    assign zeroSel = (rdAddr[p] == IDX_W'(NUM_GPR)) && !rdSpMode[p];
    assign rawVal  = zeroSel ? '0 : gprQ[rdAddr[p]];

    always_comb begin
      case (accSize_e'(rdSize[p]))
        SZ_BYTE:
          rdData[p] = rdSign[p] ? {{(DATA_W-8){rawVal[7]}}, rawVal[7:0]}
                                : {{(DATA_W-8){1'b0}}, rawVal[7:0]};
        SZ_HALF:
          rdData[p] = rdSign[p] ? {{(DATA_W-16){rawVal[15]}}, rawVal[15:0]}
                                : {{(DATA_W-16){1'b0}}, rawVal[15:0]};
        SZ_WORD:
          rdData[p] = rdSign[p] ? {{(DATA_W-HALF_W){rawVal[HALF_W-1]}}, rawVal[HALF_W-1:0]}
                                : {{(DATA_W-HALF_W){1'b0}}, rawVal[HALF_W-1:0]};
        default:
          rdData[p] = rawVal;
      endcase
    end
  end

  // R7
  flag_unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.flagOp != FLG_HOLD) |=> (((flagsOut ^ $past(flagsOut)) & ~$past(maskEff)) == '0));

  // R7
  flag_hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.flagOp == FLG_HOLD) |=> $stable(flagsOut));
endmodule

// File: rtl/aliased_gpr_file.sv
module aliased_gpr_file
  import gpr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        rdAddrA,
  input  logic              rdSpModeA,
  input  logic [1:0]        rdSizeA,
  input  logic              rdSignA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  input  logic              rdSpModeB,
  input  logic [1:0]        rdSizeB,
  input  logic              rdSignB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic              wrSpMode,
  input  logic              wrWide,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linkSave,
  input  logic [DATA_W-1:0] linkAddr,
  input  logic [1:0]        flagOp,
  input  logic [7:0]        flagMask,
  input  logic [7:0]        flagValue,
  output logic [3:0]        flagsOut
);
  localparam int HALF_W = DATA_W / 2;

  ctrl_t                         ctrl;
  logic [NUM_RD-1:0][DATA_W-1:0] rdBus;

  gpr_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrSpMode (wrSpMode),
    .wrWide   (wrWide),
    .linkSave (linkSave),
    .flagOpIn (flagOp),
    .ctrl     (ctrl)
  );

  gpr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .wrData    (wrData),
    .linkAddr  (linkAddr),
    .flagMask  (flagMask),
    .flagValue (flagValue),
    .rdAddr    ({rdAddrB, rdAddrA}),
    .rdSpMode  ({rdSpModeB, rdSpModeA}),
    .rdSize    ({rdSizeB, rdSizeA}),
    .rdSign    ({rdSignB, rdSignA}),
    .rdData    (rdBus),
    .flagsOut  (flagsOut)
  );

  assign rdDataA = rdBus[0];
  assign rdDataB = rdBus[1];

  // R1
  zero_alias_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == 5'd31 && !rdSpModeA) |-> (rdDataA == '0));

  // R5
  byte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rdSizeB == 2'd0 && !rdSignB) |-> (rdDataB[DATA_W-1:8] == '0));

  // R4
  narrow_write_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrWide && (wrAddr != 5'd31 || wrSpMode) && !(linkSave && wrAddr == 5'd30))
    |=> (rdAddrA != $past(wrAddr) || rdSizeA != 2'd3 || rdSpModeA != $past(wrSpMode)
         || rdDataA[DATA_W-1:HALF_W] == '0));

  // R8
  link_save_chk: assert property (@(posedge clk) disable iff (rst)
    linkSave |=> (rdAddrB != 5'd30 || rdSizeB != 2'd3 || rdDataB == $past(linkAddr)));
endmodule

// File: tb/aliased_gpr_file_tb.sv
`timescale 1ns/1ps
module aliased_gpr_file_tb;
  logic        clk = 0;
  logic        rst;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic        rdSpModeA, rdSpModeB, rdSignA, rdSignB;
  logic [1:0]  rdSizeA, rdSizeB, flagOp;
  logic [63:0] rdDataA, rdDataB, wrData, linkAddr;
  logic        wrEn, wrSpMode, wrWide, linkSave;
  logic [7:0]  flagMask, flagValue;
  logic [3:0]  flagsOut;

  logic [63:0] mdl [32];
  logic [3:0]  fMdl;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aliased_gpr_file u_dut (
    .clk(clk), .rst(rst),
    .rdAddrA(rdAddrA), .rdSpModeA(rdSpModeA), .rdSizeA(rdSizeA), .rdSignA(rdSignA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdSpModeB(rdSpModeB), .rdSizeB(rdSizeB), .rdSignB(rdSignB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSpMode(wrSpMode), .wrWide(wrWide), .wrData(wrData),
    .linkSave(linkSave), .linkAddr(linkAddr),
    .flagOp(flagOp), .flagMask(flagMask), .flagValue(flagValue), .flagsOut(flagsOut)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expRd(int a, bit m, int sz, bit sg);
    logic [63:0] r;
    r = (a == 31 && !m) ? 64'd0 : mdl[a];
    case (sz)
      0: return sg ? {{56{r[7]}}, r[7:0]} : {56'd0, r[7:0]};
      1: return sg ? {{48{r[15]}}, r[15:0]} : {48'd0, r[15:0]};
      2: return sg ? {{32{r[31]}}, r[31:0]} : {32'd0, r[31:0]};
      default: return r;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 32; a++)
      for (int m = 0; m < 2; m++)
        for (int sz = 0; sz < 4; sz++)
          for (int sg = 0; sg < 2; sg++) begin
            rdAddrA = 5'(a); rdSpModeA = m[0]; rdSizeA = 2'(sz); rdSignA = sg[0];
            rdAddrB = 5'(31 - a); rdSpModeB = ~m[0]; rdSizeB = 2'(3 - sz); rdSignB = ~sg[0];
            #1;
            check(tag, rdDataA, expRd(a, m[0], sz, sg[0]));
            check(tag, rdDataB, expRd(31 - a, ~m[0], 3 - sz, ~sg[0]));
          end
  endtask

  task automatic doWrite(int a, bit m, bit wide, logic [63:0] d);
    wrEn = 1; wrAddr = 5'(a); wrSpMode = m; wrWide = wide; wrData = d;
    tick();
    wrEn = 0;
    if (a != 31 || m) mdl[a] = wide ? d : {32'd0, d[31:0]};
  endtask

  task automatic flagStep(logic [1:0] op, logic [7:0] msk, logic [7:0] val, string tag);
    flagOp = op; flagMask = msk; flagValue = val;
    tick();
    flagOp = 2'd0;
    case (op)
      2'd1: fMdl = (fMdl & ~msk[3:0]) | (val[3:0] & msk[3:0]);
      2'd2: fMdl = fMdl | msk[3:0];
      2'd3: fMdl = fMdl & ~msk[3:0];
      default: ;
    endcase
    check(tag, {60'd0, flagsOut}, {60'd0, fMdl});
  endtask

  task automatic readA(int a, bit m);
    rdAddrA = 5'(a); rdSpModeA = m; rdSizeA = 2'd3; rdSignA = 0;
    #1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; wrEn = 0; wrAddr = 0; wrSpMode = 0; wrWide = 1; wrData = 0;
    linkSave = 0; linkAddr = 0; flagOp = 0; flagMask = 0; flagValue = 0;
    rdAddrA = 0; rdSpModeA = 0; rdSizeA = 0; rdSignA = 0;
    rdAddrB = 0; rdSpModeB = 0; rdSizeB = 0; rdSignB = 0;
    for (int i = 0; i < 32; i++) mdl[i] = 64'd0;
    fMdl = 0;
    // preload state so reset has something to clear
    @(negedge clk); rst = 0;
    wrEn = 1; wrAddr = 5'd3; wrSpMode = 1; wrData = 64'h1234; flagOp = 2'd2; flagMask = 8'h0F;
    tick();
    rst = 1; wrEn = 0; flagOp = 0;
    tick(); tick();
    rst = 0;

    // R10: everything cleared
    sweep("R10");
    check("R10", {60'd0, flagsOut}, 64'd0);

    // R3 / R1 / R5: fill every entry, stack pointer via mode 1
    for (int i = 0; i < 32; i++)
      doWrite(i, 1, 1, 64'hF1E2_D3C4_B5A6_9788 ^ (64'(i) * 64'h0101_0103_0107_0109));
    sweep("R5");
    readA(31, 1); check("R3", rdDataA, mdl[31]);
    readA(31, 0); check("R1", rdDataA, 64'd0);
    readA(0, 1);  check("R3", rdDataA, mdl[0]);

    // R2: zero-mode writes to index 31 are dropped
    doWrite(31, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    doWrite(31, 0, 0, 64'h0BAD_0BAD_0BAD_0BAD);
    readA(31, 1); check("R2", rdDataA, mdl[31]);
    sweep("R2");

    // R4: narrow writes clear the upper half
    for (int i = 0; i < 32; i += 5)
      doWrite(i, 1, 0, 64'hDEAD_BEEF_8765_4321 ^ 64'(i));
    doWrite(31, 1, 0, 64'hCAFE_F00D_9000_0001);
    for (int i = 0; i < 32; i += 5) begin
      readA(i, 1); check("R4", rdDataA, {32'd0, 32'h8765_4321 ^ 32'(i)});
    end
    readA(31, 1); check("R4", rdDataA, 64'h0000_0000_9000_0001);
    sweep("R5");

    // R9: same-cycle read sees old value, new value after the edge
    wrEn = 1; wrAddr = 5'd7; wrSpMode = 0; wrWide = 1; wrData = 64'h7777_0000_1111_2222;
    readA(7, 0); check("R9", rdDataA, mdl[7]);
    tick(); wrEn = 0; mdl[7] = 64'h7777_0000_1111_2222;
    readA(7, 0); check("R9", rdDataA, mdl[7]);

    // R8: link save
    linkSave = 1; linkAddr = 64'h0000_4000_0000_1004;
    tick(); linkSave = 0; mdl[30] = 64'h0000_4000_0000_1004;
    readA(30, 0); check("R8", rdDataA, mdl[30]);

    // R11: link save beats a general write to register 30
    linkSave = 1; linkAddr = 64'h0000_5000_0000_2008;
    wrEn = 1; wrAddr = 5'd30; wrWide = 1; wrData = 64'hEEEE_EEEE_EEEE_EEEE;
    tick(); linkSave = 0; wrEn = 0; mdl[30] = 64'h0000_5000_0000_2008;
    readA(30, 0); check("R11", rdDataA, mdl[30]);
    // R11: a write elsewhere still lands
    linkSave = 1; linkAddr = 64'h0000_6000_0000_300C;
    wrEn = 1; wrAddr = 5'd5; wrWide = 1; wrData = 64'h5555_AAAA_5555_AAAA;
    tick(); linkSave = 0; wrEn = 0;
    mdl[30] = 64'h0000_6000_0000_300C; mdl[5] = 64'h5555_AAAA_5555_AAAA;
    readA(30, 0); check("R11", rdDataA, mdl[30]);
    readA(5, 0);  check("R11", rdDataA, mdl[5]);
    sweep("R3");

    // R7: masked loads over all mask/value pairs, junk in upper bits
    for (int m = 0; m < 16; m++)
      for (int v = 0; v < 16; v++)
        flagStep(2'd1, {4'(v ^ 5), 4'(m)}, {4'(m ^ 9), 4'(v)}, "R7");
    // R7: set and clear sweeps
    for (int m = 0; m < 16; m++) begin
      flagStep(2'd3, 8'hFF, 8'h00, "R7");
      flagStep(2'd2, {4'hF, 4'(m)}, 8'h00, "R7");
      flagStep(2'd3, {4'hA, 4'(m ^ 6)}, 8'h00, "R7");
      flagStep(2'd0, 8'hFF, 8'hFF, "R7");
    end
    // R6: bit order and discarded upper bits
    flagStep(2'd3, 8'hFF, 8'h00, "R6");
    flagStep(2'd1, 8'h08, 8'hFF, "R6");
    check("R6", {60'd0, flagsOut}, 64'h8);
    flagStep(2'd2, 8'hF0, 8'h00, "R6");
    check("R6", {60'd0, flagsOut}, 64'h8);
    flagStep(2'd1, 8'hF1, 8'hF1, "R6");
    check("R6", {60'd0, flagsOut}, 64'h9);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule